// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This controller turns a simple synchronous request stream into the strobe sequences of an asynchronous extended-data-out DRAM. The array holds 4M words of 4 bits. Each request carries a 22-bit word address, a write flag and 4 bits of write data. The controller splits the address into a 12-bit row (upper bits) and a 10-bit column (lower bits), and presents them in turn on one shared 12-bit address bus. It drives active-low row strobe, column strobe, write enable and output enable. Reads return their data with a one-cycle valid pulse.

After an access the row stays open. A later request to the same row pulses only the column strobe, which is page mode. The page closes, with a full precharge, in three cases: a request goes to a different row, an external refresh unit raises its request, or the row strobe has been low long enough to approach its maximum width. A refresh unit gets a grant only while both strobes are high and precharge is met. It keeps the bus while it holds its request.

Every analog limit is given as a nanosecond parameter. Each one is turned into a clock count by rounding up against the clock-period parameter.

Top module: `edo_page_ctrl`

## Requirements
- R1: After reset the row, column, write and output strobes are all high, `mem_dq_oe` is low and `rd_valid` is low.
- R2: When the row strobe falls, `mem_addr` carries bits 21..10 of the accepted address. While the column strobe is low, `mem_addr` carries bits 9..0 of that address in its low bits, with its upper two bits zero.
- R3: Each limit is converted as ceil(ns/CLK_NS) cycles, and the following hold. The row strobe stays high at least the precharge count before it falls. Two falls of the row strobe are at least the random-cycle count apart. The row strobe stays low at least the pulse-width count. The first column fall comes at least the row-to-column count after the row fall. The column strobe stays low at least the column-pulse count and high at least the column-precharge count inside a page.
- R4: Requests to the open row are served under the same row-strobe low period, with only the column strobe toggling. Successive column falls are at least the page-cycle count apart.
- R5: When a page access changes between read and write, its column fall comes at least ceil((tCAS+tCP+2 tT)/CLK_NS) cycles after the previous one.
- R6: A request to a row other than the open one closes the page and precharges before the new row is opened.
- R7: A write is an early write. Write enable is low exactly while the column strobe is low. Output enable stays high, and `mem_dq_out` is driven with the request's data while `mem_dq_oe` is high.
- R8: For a read, the column strobe stays low for the largest of the column-pulse, column-access and address-access counts. `mem_dq_in` is captured on the last column-low cycle. `rd_valid` then pulses for exactly one cycle with the captured word. Every read returns the last word written to its address (0 if none), and results arrive in request order.
- R9: The row strobe never stays low longer than the maximum-width count. The page closes on its own even when no request arrives.
- R10: While `ref_req` is high, an open page closes and no request is accepted. `ref_gnt` is raised only with both strobes high and precharge met. After `ref_req` drops, the row strobe stays high a full precharge count before it falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 22 | Word address, row in bits 21..10, column in 9..0 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write data |
| rd_data | output | 4 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | One-cycle read-return pulse |
| ref_req | input | 1 | Refresh unit asks for the bus |
| ref_gnt | output | 1 | Bus handed to the refresh unit |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 12 | Multiplexed row/column address |
| mem_dq_out | output | 4 | Data toward the DRAM |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 4 | Data from the DRAM |

## Verification
The bench builds the controller with an 8 ns clock period and a 1600 ns maximum row-strobe width. All other limits keep their defaults, so the counts are precharge 5, pulse 8, random cycle 13, row-to-column 2, column pulse and precharge 2, page cycle 4, mixed cycle 3 and read column-low 4. The short maximum width makes the page time out after about 200 cycles, which brings the forced close within reach of a short run. The small cycle counts let page hits, row misses, read/write mixes inside one page and refresh pre-emption all occur many times in a few hundred random requests over a handful of rows.

// File: rtl/edo_page_ctrl.sv
`timescale 1ns/1ps
module edo_page_ctrl #(
  parameter int CLK_NS      = 10,
  parameter int T_RC_NS     = 104,
  parameter int T_RP_NS     = 40,
  parameter int T_RAS_NS    = 60,
  parameter int T_RASMAX_NS = 100000,
  parameter int T_RCD_NS    = 14,
  parameter int T_CAS_NS    = 10,
  parameter int T_CP_NS     = 10,
  parameter int T_HPC_NS    = 25,
  parameter int T_AA_NS     = 30,
  parameter int T_CAC_NS    = 15,
  parameter int T_TR_NS     = 2,
  parameter int ROW_W       = 12,
  parameter int COL_W       = 10,
  parameter int DQ_W        = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic [DQ_W-1:0]        rd_data,
  output logic                   rd_valid,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  output logic                   mem_ras_n,
  output logic                   mem_cas_n,
  output logic                   mem_we_n,
  output logic                   mem_oe_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
  output logic [DQ_W-1:0]        mem_dq_out,
  output logic                   mem_dq_oe,
  input  logic [DQ_W-1:0]        mem_dq_in
);
  function automatic int to_cyc(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MA_W     = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int N_RC     = to_cyc(T_RC_NS);
  localparam int N_RP     = to_cyc(T_RP_NS);
  localparam int N_RAS    = to_cyc(T_RAS_NS);
  localparam int N_RASMAX = to_cyc(T_RASMAX_NS);
  localparam int N_RCD    = to_cyc(T_RCD_NS);
  localparam int N_CAS    = to_cyc(T_CAS_NS);
  localparam int N_CP     = to_cyc(T_CP_NS);
  localparam int N_HPC    = to_cyc(T_HPC_NS);
  localparam int N_MIX    = to_cyc(T_CAS_NS + T_CP_NS + 2 * T_TR_NS);
  localparam int N_RDL    = imax(N_CAS, imax(to_cyc(T_AA_NS), to_cyc(T_CAC_NS)));
  localparam int N_LIM    = N_RASMAX - N_RDL - N_CP - 2;
  localparam int CW       = $clog2(N_RASMAX + N_RC + 4) + 1;

  localparam logic [CW-1:0] K_RC1  = CW'(N_RC - 1);
  localparam logic [CW-1:0] K_RP1  = CW'(N_RP - 1);
  localparam logic [CW-1:0] K_RAS1 = CW'(N_RAS - 1);
  localparam logic [CW-1:0] K_RCD1 = CW'(N_RCD - 1);
  localparam logic [CW-1:0] K_WRL1 = CW'(N_CAS - 1);
  localparam logic [CW-1:0] K_RDL1 = CW'(N_RDL - 1);
  localparam logic [CW-1:0] K_CP1  = CW'(N_CP - 1);
  localparam logic [CW-1:0] K_HPC1 = CW'(N_HPC - 1);
  localparam logic [CW-1:0] K_MIX1 = CW'(N_MIX - 1);
  localparam logic [CW-1:0] K_LIM  = CW'(N_LIM);

  typedef enum logic [1:0] {S_IDLE, S_RCD, S_CAS, S_CP} st_t;

  st_t              st;
  logic [CW-1:0]    cnt, age, pc, cyc_c;
  logic [ROW_W-1:0] open_row;
  logic [COL_W-1:0] col_q;
  logic             we_q, last_we, gnt_q;
  logic [DQ_W-1:0]  wd_q;

  wire [ROW_W-1:0] req_row = req_addr[ROW_W+COL_W-1:COL_W];
  wire [COL_W-1:0] req_col = req_addr[COL_W-1:0];

  wire idle_ok   = (pc >= K_RP1) && (age >= K_RC1);
  wire cp_min    = (cnt >= K_CP1) && (cyc_c >= K_HPC1);
  wire expire    = age >= K_LIM;
  wire hit       = req_valid && (req_row == open_row);
  wire mix_ok    = (req_we == last_we) || (cyc_c >= K_MIX1);
  wire take_idle = (st == S_IDLE) && idle_ok && !ref_req && req_valid;
  wire take_hit  = (st == S_CP) && cp_min && !ref_req && !expire && hit && mix_ok;
  wire close_pg  = (st == S_CP) && cp_min && (age >= K_RAS1) &&
                   (ref_req || expire || (req_valid && !hit));

  assign req_ready  = take_idle || take_hit;
  assign ref_gnt    = (st == S_IDLE) && ref_req && (gnt_q || idle_ok);
  assign mem_ras_n  = (st == S_IDLE);
  assign mem_cas_n  = (st != S_CAS);
  assign mem_we_n   = !((st == S_CAS) && we_q);
  assign mem_oe_n   = !((st == S_CAS) && !we_q);
  assign mem_dq_oe  = (st == S_CAS) && we_q;
  assign mem_dq_out = wd_q;
  assign mem_addr   = (st == S_CAS) ? MA_W'(col_q) : MA_W'(open_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; age <= CW'(N_RC); pc <= CW'(N_RP); cyc_c <= '0;
      open_row <= '0; col_q <= '0; we_q <= 1'b0; wd_q <= '0; last_we <= 1'b0;
      gnt_q <= 1'b0; rd_data <= '0; rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      gnt_q    <= ref_gnt;
      cnt      <= (cnt   == '1) ? cnt   : cnt   + 1'b1;
      age      <= (age   == '1) ? age   : age   + 1'b1;
      pc       <= (pc    == '1) ? pc    : pc    + 1'b1;
      cyc_c    <= (cyc_c == '1) ? cyc_c : cyc_c + 1'b1;
      case (st)
        S_IDLE:
          if (ref_gnt) pc <= '0;
          else if (take_idle) begin
            st <= S_RCD; cnt <= '0; age <= '0;
            open_row <= req_row; col_q <= req_col; we_q <= req_we; wd_q <= req_wdata;
          end
        S_RCD:
          if (cnt >= K_RCD1) begin st <= S_CAS; cnt <= '0; cyc_c <= '0; end
        S_CAS:
          if (cnt >= (we_q ? K_WRL1 : K_RDL1)) begin
            st <= S_CP; cnt <= '0; last_we <= we_q;
            if (!we_q) begin rd_data <= mem_dq_in; rd_valid <= 1'b1; end
          end
        S_CP:
          if (close_pg) begin
            st <= S_IDLE; cnt <= '0; pc <= '0;
          end else if (take_hit) begin
            st <= S_CAS; cnt <= '0; cyc_c <= '0;
            col_q <= req_col; we_q <= req_we; wd_q <= req_wdata;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] chk_hi, chk_lo;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_hi <= CW'(N_RP); chk_lo <= '0;
    end else begin
      chk_hi <= !mem_ras_n ? '0 : ((chk_hi == '1) ? chk_hi : chk_hi + 1'b1);
      chk_lo <=  mem_ras_n ? '0 : ((chk_lo == '1) ? chk_lo : chk_lo + 1'b1);
    end
  end

  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> (chk_hi >= CW'(N_RP)));                   // R3
  AST_RAS_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ras_n) |-> (chk_lo >= CW'(N_RAS)));                  // R3
  AST_RAS_MAX_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ras_n |-> (chk_lo < CW'(N_RASMAX)));                      // R9
  AST_CAS_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cas_n |-> !mem_ras_n);                                    // R4
  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_cas_n && mem_dq_oe));          // R7
  AST_COL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cas_n && $past(!mem_cas_n)) |-> $stable(mem_addr));      // R2
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);                                       // R8
  AST_GNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (mem_ras_n && mem_cas_n && !req_ready));           // R10
endmodule

// File: tb/edo_page_ctrl_test.sv
`timescale 1ns/1ps
module edo_page_ctrl_test;
  function automatic int cdiv(int ns);
    return (ns + 7) / 8;
  endfunction
  localparam int E_RP = cdiv(40), E_RC = cdiv(104), E_RAS = cdiv(60), E_RMAX = cdiv(1600);
  localparam int E_RCD = cdiv(14), E_CAS = cdiv(10), E_CP = cdiv(10), E_HPC = cdiv(25);
  localparam int E_MIX = cdiv(10 + 10 + 4);
  localparam int E_RDL = (cdiv(30) > cdiv(15)) ? cdiv(30) : cdiv(15);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, ref_req = 0;
  logic [21:0] req_addr = '0;
  logic [3:0] req_wdata = '0, mem_dq_in = '0;
  logic req_ready, rd_valid, ref_gnt, mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [3:0] rd_data, mem_dq_out;
  logic [11:0] mem_addr;

  edo_page_ctrl #(.CLK_NS(8), .T_RASMAX_NS(1600)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, ras_falls = 0, reads_out = 0, rd_seen = 0;
  bit done = 0;
  logic [3:0] ref_mem [int];
  logic [3:0] dram [int];
  logic [3:0] exp_q [$];
  logic [21:0] acc_addr = '0;
  logic [3:0] acc_wd = '0;
  logic [11:0] cur_row = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] ref_rd(input logic [21:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 4'h0;
  endfunction

  task automatic do_req(input logic [21:0] a, input logic w, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_we = w; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc_addr = a; acc_wd = d;
    if (w) ref_mem[int'(a)] = d; else begin exp_q.push_back(ref_rd(a)); reads_out++; end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  // DRAM model and timing monitor, sampled away from the active edge
  logic p_ras = 1, p_cas = 1, first_cas = 0, last_op_we = 0, cur_rd = 0;
  int hi_run = 1000, lo_run = 0, cas_lo = 0, cas_hi = 0, since_rf = 1000, since_cf = 1000;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !mem_ras_n) begin
        check(hi_run >= E_RP, "R3 precharge", hi_run, E_RP);
        check(since_rf >= E_RC, "R3 random cycle", since_rf, E_RC);
        check(mem_addr == acc_addr[21:10], "R2 row", mem_addr, acc_addr[21:10]);
        cur_row = mem_addr; ras_falls++; first_cas = 1;
      end
      if (!p_ras && mem_ras_n) begin
        check(lo_run >= E_RAS, "R3 ras width", lo_run, E_RAS);
        check(lo_run <= E_RMAX, "R9 ras max", lo_run, E_RMAX);
      end
      if (p_cas && !mem_cas_n) begin
        if (first_cas) check(since_rf >= E_RCD, "R3 ras-to-cas", since_rf, E_RCD);
        else begin
          check(cas_hi >= E_CP, "R3 cas precharge", cas_hi, E_CP);
          check(since_cf >= E_HPC, "R4 page cycle", since_cf, E_HPC);
          if (last_op_we != !mem_we_n)
            check(since_cf >= E_MIX, "R5 mixed cycle", since_cf, E_MIX);
        end
        check(mem_addr == {2'b00, acc_addr[9:0]}, "R2 column", mem_addr, acc_addr[9:0]);
        last_op_we = !mem_we_n; cur_rd = mem_we_n; first_cas = 0;
        if (!mem_we_n) begin
          check(mem_oe_n && mem_dq_oe && mem_dq_out == acc_wd, "R7 early write",
                mem_dq_out, acc_wd);
          dram[int'({cur_row, mem_addr[9:0]})] = mem_dq_out;
        end else begin
          check(mem_oe_n == 0, "R8 read oe", mem_oe_n, 0);
          mem_dq_in = dram.exists(int'({cur_row, mem_addr[9:0]})) ?
                      dram[int'({cur_row, mem_addr[9:0]})] : 4'h0;
        end
      end
      if (!p_cas && mem_cas_n)
        check(cas_lo >= (cur_rd ? E_RDL : E_CAS), "R8 cas low length", cas_lo,
              cur_rd ? E_RDL : E_CAS);
      if (!mem_cas_n && mem_ras_n) check(0, "R4 cas outside row", 1, 0);
      if (rd_valid) begin
        rd_seen++;
        if (exp_q.size() == 0) check(0, "R8 unexpected rd_valid", 1, 0);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R8 read data", rd_data, e);
        end
      end
      since_rf = (p_ras && !mem_ras_n) ? 1 : since_rf + 1;
      since_cf = (p_cas && !mem_cas_n) ? 1 : since_cf + 1;
      hi_run = mem_ras_n ? hi_run + 1 : 0;
      lo_run = mem_ras_n ? 0 : lo_run + 1;
      cas_lo = mem_cas_n ? 0 : cas_lo + 1;
      cas_hi = (mem_cas_n && !mem_ras_n) ? cas_hi + 1 : 0;
      p_ras = mem_ras_n; p_cas = mem_cas_n;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c0;
    int seed;
    bit got;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(mem_ras_n && mem_cas_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
          "R1 reset state", {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}, 4'hF);

    // R7 R8 write then read back
    do_req({12'd5, 10'd3}, 1, 4'h9);
    do_req({12'd5, 10'd3}, 0, 4'h0);
    do_req({12'd5, 10'd4}, 0, 4'h0);

    // R4 page hits: one row-strobe fall for a run of same-row accesses
    c0 = ras_falls;
    do_req({12'd7, 10'd1}, 1, 4'hA);
    do_req({12'd7, 10'd2}, 1, 4'h5);
    do_req({12'd7, 10'd1}, 0, 4'h0);
    do_req({12'd7, 10'd2}, 0, 4'h0);
    do_req({12'd7, 10'd9}, 1, 4'h3);
    repeat (12) @(negedge clk);
    check(ras_falls - c0 == 1, "R4 same-row single activation", ras_falls - c0, 1);

    // R6 row misses
    c0 = ras_falls;
    do_req({12'd8, 10'd0}, 1, 4'h1);
    do_req({12'd9, 10'd0}, 0, 4'h0);
    repeat (20) @(negedge clk);
    check(ras_falls - c0 == 2, "R6 row miss reopens", ras_falls - c0, 2);

    // R9 page timeout with no traffic
    do_req({12'd10, 10'd7}, 0, 4'h0);
    repeat (E_RMAX + 40) @(negedge clk);
    check(mem_ras_n == 1, "R9 page closed by timeout", mem_ras_n, 1);

    // R10 refresh pre-empts an open page
    do_req({12'd11, 10'd2}, 1, 4'h6);
    @(negedge clk);
    ref_req = 1; req_valid = 1; req_addr = {12'd11, 10'd3}; req_we = 1; req_wdata = 4'hC;
    got = 0;
    for (int i = 0; i < 60 && !got; i++) begin
      @(negedge clk); #1;
      if (ref_gnt) got = 1;
      else check(!req_ready, "R10 no accept while refresh pending", req_ready, 0);
    end
    check(got, "R10 grant reached", got, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      check(ref_gnt && mem_ras_n && mem_cas_n && !req_ready, "R10 bus quiet in grant",
            {ref_gnt, mem_ras_n, mem_cas_n, req_ready}, 4'hE);
    end
    req_valid = 0; ref_req = 0;
    do_req({12'd11, 10'd3}, 1, 4'hC);
    do_req({12'd11, 10'd2}, 0, 4'h0);
    do_req({12'd11, 10'd3}, 0, 4'h0);

    // random traffic over a few rows: hits, misses, mixed pages, refresh bursts
    for (int k = 0; k < 400; k++) begin
      logic [21:0] a;
      a = {12'($urandom_range(0, 4)), 10'($urandom_range(0, 7))};
      if ($urandom_range(0, 39) == 0) begin
        @(negedge clk); ref_req = 1;
        repeat ($urandom_range(2, 25)) @(negedge clk);
        ref_req = 0;
      end
      do_req(a, 1'($urandom_range(0, 1)), 4'($urandom));
    end

    repeat (40) @(negedge clk);
    check(rd_seen == reads_out, "R8 one pulse per read", rd_seen, reads_out);
    check(exp_q.size() == 0, "R8 no read left pending", exp_q.size(), 0);
    finish_run();
  end
endmodule